// File: doc/BRIEF.md
# Polled Four-Channel Packet Ring Controller

This block moves packets between a packet interface and rings in host memory on four independent channels. Each channel has a receive ring and a transmit ring. Nothing in the block raises an interrupt. Software finds new data by polling producer indices, and it hands work to the block by writing pointer values.

On receive, a packet word arrives with a channel tag. The block writes the word into the next free slot of that channel's receive ring and advances the channel's producer index. When the ring is full the word is dropped and counted, and software frees slots by writing the channel's consumer index.

On transmit, software fills slots in a transmit ring and then writes that channel's tail pointer. The block then reads the pending slots from memory on its own. It serves the waiting channels round-robin, one slot per turn, and sends each returned word out on the transmit stream with its channel tag.

In this model one slot holds one packet word. A behavioural memory answers the request port.

Top module: `dring_ctrl`

## Requirements
- R1: A receive word for channel c that is accepted is written with one request to address {bit10=0, bits9:8=c, bits7:0=producer index}. The producer index of channel c then advances by one, wrapping from 255 to 0.
- R2: A receive ring is full when (producer+1) mod 256 equals its consumer index. A word arriving for a full channel is not written. That channel's drop counter increments by one and its producer index holds.
- R3: A pointer write with select 0 and a value from 0 to 255 sets the consumer index of the addressed channel, which frees receive slots for new words.
- R4: A pointer write whose value is 256 or more is ignored. This holds for select 0 (receive consumer) and for select 1 (transmit tail).
- R5: A pointer write with select 1 sets a channel's transmit tail. For each slot from head up to tail-1, the block issues one read to address {bit10=1, bits9:8=channel, bits7:0=slot}, advances the head, and emits the returned word on the transmit stream tagged with that channel.
- R6: Channels with head different from tail are served round-robin, one slot per grant, with channel 0 first after reset.
- R7: No transmit read is issued in the cycle after a cycle with receive input valid. Receive writes have priority on the memory port.
- R8: At most one transmit read is outstanding. A new read waits for the previous response.
- R9: After reset, all indices and drop counters are zero and no request or transmit word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Pointer write strobe |
| reg_wr_sel | input | 1 | 0 = receive consumer, 1 = transmit tail |
| reg_wr_chan | input | 2 | Channel addressed by the pointer write |
| reg_wr_val | input | 16 | Pointer value; values of 256 or more are ignored |
| rx_vld | input | 1 | Receive word valid |
| rx_chan | input | 2 | Receive channel tag |
| rx_data | input | 32 | Receive word |
| mem_req_vld | output | 1 | Memory request valid |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 11 | {direction, channel, slot} |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_vld | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| tx_vld | output | 1 | Transmit word valid |
| tx_chan | output | 2 | Transmit channel tag |
| tx_data | output | 32 | Transmit word |
| rx_prod_idx | output | 32 | Producer index of each channel, 8 bits each, channel 0 in the low bits |
| tx_head_idx | output | 32 | Transmit head of each channel, 8 bits each |
| rx_drop_cnt | output | 64 | Drop counter of each channel, 16 bits each |

## Verification
The hardest condition to reach is several transmit channels waiting at the same moment, because the block starts fetching as soon as a single tail is written. The stimulus holds receive traffic on the port while it writes three tails, since receive input blocks transmit reads. When the traffic stops, all three channels are waiting together, and the scoreboard checks the interleaved round-robin order. A full receive ring is reached by streaming 256 words into one channel without returning slots. An out-of-range consumer write is made visible by choosing a value whose truncated low bits would shrink the ring, so a wrong design drops a word.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int DEF_NCH    = 4;
    localparam int DEF_SLOT_W = 8;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_REG_W  = 16;
    localparam int DEF_CNT_W  = 16;

    typedef enum logic {
        SEL_RX_CONS = 1'b0,
        SEL_TX_TAIL = 1'b1
    } ptr_sel_e;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } ring_dir_e;

    // true when a pointer value lies inside a ring of 2**w slots
    function automatic logic fits_ring(input logic [31:0] v, input int w);
        return (v >> w) == 32'd0;
    endfunction

endpackage

// File: rtl/dring_rx_chan.sv
module dring_rx_chan #(
    parameter int SLOT_W = dring_pkg::DEF_SLOT_W,
    parameter int REG_W  = dring_pkg::DEF_REG_W,
    parameter int CNT_W  = dring_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_hit,
    input  logic              cons_wr,
    input  logic [REG_W-1:0]  cons_val,
    output logic [SLOT_W-1:0] prod,
    output logic              accept,
    output logic [CNT_W-1:0]  drop_cnt
);
    logic [SLOT_W-1:0] cons;
    logic [SLOT_W-1:0] prod_nxt;
    logic              full;
    logic              cons_ok;

    always_comb begin
        prod_nxt = prod + 1'b1;
        full     = (prod_nxt == cons);
        accept   = pkt_hit && !full;
        cons_ok  = dring_pkg::fits_ring(32'(cons_val), SLOT_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod     <= '0;
            cons     <= '0;
            drop_cnt <= '0;
        end else begin
            if (accept)
                prod <= prod_nxt;
            if (pkt_hit && full)
                drop_cnt <= drop_cnt + 1'b1;
            if (cons_wr && cons_ok)
                cons <= cons_val[SLOT_W-1:0];
        end
    end

    assert_full_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_hit && full) |=> (prod == $past(prod)) && (drop_cnt == $past(drop_cnt) + 1'b1));

    assert_cons_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (cons_wr && !cons_ok) |=> $stable(cons));

endmodule

// File: rtl/dring_tx_sched.sv
module dring_tx_sched #(
    parameter int NCH    = dring_pkg::DEF_NCH,
    parameter int SLOT_W = dring_pkg::DEF_SLOT_W,
    parameter int REG_W  = dring_pkg::DEF_REG_W,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tail_wr,
    input  logic [CH_W-1:0]       tail_chan,
    input  logic [REG_W-1:0]      tail_val,
    input  logic                  hold,
    input  logic                  rsp_vld,
    output logic                  issue,
    output logic [CH_W-1:0]       pick,
    output logic [SLOT_W-1:0]     issue_slot,
    output logic                  busy,
    output logic [CH_W-1:0]       owner,
    output logic [NCH*SLOT_W-1:0] heads_flat
);
    logic [SLOT_W-1:0] head [NCH];
    logic [SLOT_W-1:0] tail [NCH];
    logic [NCH-1:0]    pend;
    logic [CH_W-1:0]   last;
    logic [CH_W-1:0]   idx;
    logic              found;

    always_comb begin
        for (int c = 0; c < NCH; c++)
            pend[c] = (head[c] != tail[c]);
        pick  = '0;
        found = 1'b0;
        idx   = '0;
        for (int off = 1; off <= NCH; off++) begin
            idx = CH_W'((int'(last) + off) % NCH);
            if (!found && pend[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
        issue      = found && !busy && !hold;
        issue_slot = head[pick];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                head[c] <= '0;
                tail[c] <= '0;
            end
            last  <= CH_W'(NCH - 1);
            busy  <= 1'b0;
            owner <= '0;
        end else begin
            if (tail_wr && dring_pkg::fits_ring(32'(tail_val), SLOT_W))
                tail[tail_chan] <= tail_val[SLOT_W-1:0];
            if (issue) begin
                head[pick] <= head[pick] + 1'b1;
                last       <= pick;
                busy       <= 1'b1;
                owner      <= pick;
            end else if (rsp_vld) begin
                busy <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_heads
        assign heads_flat[g*SLOT_W +: SLOT_W] = head[g];
    end

    assert_single_rd_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !issue);

    assert_head_lag_R5: assert property (@(posedge clk) disable iff (rst)
        issue |-> (head[pick] != tail[pick]));

endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl #(
    parameter int NCH    = dring_pkg::DEF_NCH,
    parameter int SLOT_W = dring_pkg::DEF_SLOT_W,
    parameter int DATA_W = dring_pkg::DEF_DATA_W,
    parameter int REG_W  = dring_pkg::DEF_REG_W,
    parameter int CNT_W  = dring_pkg::DEF_CNT_W,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = 1 + CH_W + SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic                  reg_wr_sel,
    input  logic [CH_W-1:0]       reg_wr_chan,
    input  logic [REG_W-1:0]      reg_wr_val,
    input  logic                  rx_vld,
    input  logic [CH_W-1:0]       rx_chan,
    input  logic [DATA_W-1:0]     rx_data,
    output logic                  mem_req_vld,
    output logic                  mem_req_we,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [DATA_W-1:0]     mem_req_wdata,
    input  logic                  mem_rsp_vld,
    input  logic [DATA_W-1:0]     mem_rsp_data,
    output logic                  tx_vld,
    output logic [CH_W-1:0]       tx_chan,
    output logic [DATA_W-1:0]     tx_data,
    output logic [NCH*SLOT_W-1:0] rx_prod_idx,
    output logic [NCH*SLOT_W-1:0] tx_head_idx,
    output logic [NCH*CNT_W-1:0]  rx_drop_cnt
);
    import dring_pkg::*;

    logic [SLOT_W-1:0] prod [NCH];
    logic [NCH-1:0]    acc;
    logic              rx_take;
    logic              tx_issue;
    logic [CH_W-1:0]   tx_pick;
    logic [SLOT_W-1:0] tx_slot;
    logic              tx_busy;
    logic [CH_W-1:0]   tx_owner;
    logic              tail_wr;

    for (genvar g = 0; g < NCH; g++) begin : g_rx
        logic hit;
        logic cwr;
        assign hit = rx_vld && (rx_chan == CH_W'(g));
        assign cwr = reg_wr_en && (reg_wr_sel == SEL_RX_CONS) && (reg_wr_chan == CH_W'(g));
        dring_rx_chan #(.SLOT_W(SLOT_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_rx (
            .clk      (clk),
            .rst      (rst),
            .pkt_hit  (hit),
            .cons_wr  (cwr),
            .cons_val (reg_wr_val),
            .prod     (prod[g]),
            .accept   (acc[g]),
            .drop_cnt (rx_drop_cnt[g*CNT_W +: CNT_W])
        );
        assign rx_prod_idx[g*SLOT_W +: SLOT_W] = prod[g];
    end

    assign rx_take = |acc;
    assign tail_wr = reg_wr_en && (reg_wr_sel == SEL_TX_TAIL);

    dring_tx_sched #(.NCH(NCH), .SLOT_W(SLOT_W), .REG_W(REG_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tail_wr    (tail_wr),
        .tail_chan  (reg_wr_chan),
        .tail_val   (reg_wr_val),
        .hold       (rx_vld),
        .rsp_vld    (mem_rsp_vld),
        .issue      (tx_issue),
        .pick       (tx_pick),
        .issue_slot (tx_slot),
        .busy       (tx_busy),
        .owner      (tx_owner),
        .heads_flat (tx_head_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req_vld   <= 1'b0;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
            tx_vld        <= 1'b0;
            tx_chan       <= '0;
            tx_data       <= '0;
        end else begin
            mem_req_vld <= 1'b0;
            mem_req_we  <= 1'b0;
            if (rx_take) begin
                mem_req_vld   <= 1'b1;
                mem_req_we    <= 1'b1;
                mem_req_addr  <= {DIR_RX, rx_chan, prod[rx_chan]};
                mem_req_wdata <= rx_data;
            end else if (tx_issue) begin
                mem_req_vld  <= 1'b1;
                mem_req_addr <= {DIR_TX, tx_pick, tx_slot};
            end
            tx_vld  <= mem_rsp_vld && tx_busy;
            tx_chan <= tx_owner;
            tx_data <= mem_rsp_data;
        end
    end

    assert_rx_first_R7: assert property (@(posedge clk) disable iff (rst)
        rx_vld |=> !(mem_req_vld && !mem_req_we));

    assert_tx_dir_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_vld && !mem_req_we) |-> mem_req_addr[ADDR_W-1]);

endmodule

// File: tb/dring_ctrl_tb.sv
module dring_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [1:0]  reg_wr_chan = '0;
    logic [15:0] reg_wr_val = '0;
    logic        rx_vld = 1'b0;
    logic [1:0]  rx_chan = '0;
    logic [31:0] rx_data = '0;
    logic        mem_req_vld, mem_req_we;
    logic [10:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_vld = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        tx_vld;
    logic [1:0]  tx_chan;
    logic [31:0] tx_data;
    logic [31:0] rx_prod_idx, tx_head_idx;
    logic [63:0] rx_drop_cnt;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    logic [31:0] host_mem [2048];
    logic [33:0] exp_q [$];

    always #2 clk = ~clk;

    dring_ctrl u_dut (.*);

    function automatic logic [31:0] tx_word(input logic [10:0] a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    // behavioural host memory: one-cycle read latency, transmit rings computed
    always @(posedge clk) begin
        mem_rsp_vld <= 1'b0;
        if (mem_req_vld) begin
            if (mem_req_we) host_mem[mem_req_addr] <= mem_req_wdata;
            else begin
                mem_rsp_vld  <= 1'b1;
                mem_rsp_data <= mem_req_addr[10] ? tx_word(mem_req_addr) : host_mem[mem_req_addr];
                rd_cnt       <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && tx_vld) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5/R6: actual unexpected tx %0h:%0h expected none", tx_chan, tx_data);
            end else begin
                logic [33:0] e;
                e = exp_q.pop_front();
                if ({tx_chan, tx_data} !== e) begin
                    fails++;
                    $display("FAIL R5/R6: actual %0h expected %0h", {tx_chan, tx_data}, e);
                end
            end
        end
    end

    task automatic send_rx(input logic [1:0] c, input logic [31:0] d);
        @(negedge clk);
        rx_vld = 1'b1; rx_chan = c; rx_data = d;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_vld = 1'b0; reg_wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ptr(input logic sel, input logic [1:0] c, input logic [15:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_chan = c; reg_wr_val = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 prod", 64'(rx_prod_idx), 64'd0);
        check("R9 head", 64'(tx_head_idx), 64'd0);
        check("R9 drops", rx_drop_cnt, 64'd0);
        check("R9 valids", {62'd0, mem_req_vld, tx_vld}, 64'd0);

        // R1 single receive word
        send_rx(2'd1, 32'h5100_0000);
        idle(3);
        check("R1 mem write", 64'(host_mem[{1'b0, 2'd1, 8'd0}]), 64'h5100_0000);
        check("R1 prod1", 64'(rx_prod_idx[15:8]), 64'd1);

        // R2 fill channel 2
        for (int k = 0; k < 256; k++) send_rx(2'd2, 32'(k));
        idle(3);
        check("R2 prod2 held", 64'(rx_prod_idx[23:16]), 64'd255);
        check("R2 drop2", 64'(rx_drop_cnt[47:32]), 64'd1);
        check("R1 last slot", 64'(host_mem[{1'b0, 2'd2, 8'd254}]), 64'd254);

        // R3 consumer write frees slots, R1 wrap
        wr_ptr(1'b0, 2'd2, 16'd10);
        send_rx(2'd2, 32'd999);
        idle(3);
        check("R3 accepted after free", 64'(host_mem[{1'b0, 2'd2, 8'd255}]), 64'd999);
        check("R1 wrap prod2", 64'(rx_prod_idx[23:16]), 64'd0);
        check("R3 drop2 unchanged", 64'(rx_drop_cnt[47:32]), 64'd1);

        // R4 out-of-range consumer write (261 truncated would be 5)
        wr_ptr(1'b0, 2'd3, 16'd261);
        for (int k = 0; k < 5; k++) send_rx(2'd3, 32'h3300 + 32'(k));
        idle(3);
        check("R4 prod3", 64'(rx_prod_idx[31:24]), 64'd5);
        check("R4 drop3", 64'(rx_drop_cnt[63:48]), 64'd0);

        // R6 expected round-robin order
        exp_q.push_back({2'd0, tx_word({1'b1, 2'd0, 8'd0})});
        exp_q.push_back({2'd2, tx_word({1'b1, 2'd2, 8'd0})});
        exp_q.push_back({2'd3, tx_word({1'b1, 2'd3, 8'd0})});
        exp_q.push_back({2'd0, tx_word({1'b1, 2'd0, 8'd1})});
        exp_q.push_back({2'd2, tx_word({1'b1, 2'd2, 8'd1})});
        exp_q.push_back({2'd0, tx_word({1'b1, 2'd0, 8'd2})});

        // R7 tails written while receive traffic holds the port
        @(negedge clk);
        rx_vld = 1'b1; rx_chan = 2'd1; rx_data = 32'h77;
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_chan = 2'd0; reg_wr_val = 16'd3;
        @(negedge clk);
        rx_data = 32'h78; reg_wr_chan = 2'd2; reg_wr_val = 16'd2;
        @(negedge clk);
        rx_data = 32'h79; reg_wr_chan = 2'd3; reg_wr_val = 16'd1;
        @(negedge clk);
        rx_vld = 1'b0; reg_wr_en = 1'b0;
        check("R7 no read during rx", 64'(rd_cnt), 64'd0);
        repeat (30) @(negedge clk);
        check("R6 all delivered", 64'(exp_q.size()), 64'd0);
        check("R8 reads equal slots", 64'(rd_cnt), 64'd6);
        check("R5 heads", 64'(tx_head_idx), {32'd0, 8'd1, 8'd2, 8'd0, 8'd3});
        check("R7 rx words", 64'(host_mem[{1'b0, 2'd1, 8'd3}]), 64'h79);
        check("R1 prod1 after burst", 64'(rx_prod_idx[15:8]), 64'd4);

        // R4 out-of-range tail ignored
        wr_ptr(1'b1, 2'd1, 16'd400);
        idle(20);
        check("R4 tail ignored head1", 64'(tx_head_idx[15:8]), 64'd0);
        check("R4 tail ignored reads", 64'(rd_cnt), 64'd6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule